// File: doc/BRIEF.md
# Bridge Forwarding Address Decoder

This block sits beside the address phase of a two-sided bus bridge and decides, for every transaction address offered to it, whether the bridge should claim the cycle and carry it to the other side. A request from the primary (upstream) side is claimed for downstream forwarding when it lands in one of the forwarding ranges. These are an I/O window, a memory window, the legacy display ranges, and the display palette write addresses. A request from the secondary (downstream) side is claimed for upstream forwarding when it lands outside those ranges.

The windows are kept at coarse granularity. The I/O window is described by 4 KB page numbers inside a 64 KB I/O space. The memory window is described by 1 MB page numbers. Legacy ISA aliasing narrows the downstream part of the I/O window to the first quarter of each 1 KB block. Per-function enables gate the claims, and a live-insertion mask can force those enables off through a hardware pin without changing the configuration values themselves. The decision is registered, so the claim outputs reflect the request presented one clock earlier and can drive device-select timing directly.

Top module: `fwd_addr_decoder`

## Requirements
- R1: Claim outputs are 0 during reset. A request presented with `req_vld` high in one cycle sets the claims after the next rising edge. In any cycle after `req_vld` was low, both claims are 0.
- R2: A primary request (`req_side`=0) of I/O kind (`req_kind` 00 read, 01 write) is claimed downstream when `cfg_io_en` is set, address bits [31:16] are 0, and {`cfg_io_base`,000h} ≤ address ≤ {`cfg_io_limit`,FFFh}.
- R3: A primary request of memory kind (`req_kind`=10) is claimed downstream when `cfg_mem_en` is set and {`cfg_mem_base`,00000h} ≤ address ≤ {`cfg_mem_limit`,FFFFFh}.
- R4: A window whose base is above its limit matches no address.
- R5: A secondary request (`req_side`=1) is claimed upstream only when `cfg_master_en` is set and the address falls outside the window for its kind. An I/O address with nonzero bits [31:16] counts as outside the I/O window.
- R6: With `cfg_isa_en` set, an I/O address inside the window is claimed downstream only if address bits [9:8] are 00. Otherwise it is treated as outside the window, so it is forwarded upstream from the secondary side.
- R7: With `cfg_vga_en` set, primary requests to memory 000A0000h–000BFFFFh, and primary I/O requests with bits [31:16]=0 and bits [9:0] in 3B0h–3BBh or 3C0h–3DFh (bits [15:10] ignored), are claimed downstream under the matching enable, whatever the windows hold. The same addresses from the secondary side are never forwarded upstream.
- R8: With `cfg_snoop_en` set, primary I/O writes with bits [31:16]=0 and bits [9:0] equal to 3C6h, 3C8h or 3C9h are claimed downstream under `cfg_io_en`. Reads to those addresses are not claimed by this rule, and secondary-side decisions are unchanged.
- R9: With both `cfg_vga_en` and `cfg_snoop_en` set, every decision equals the one made with `cfg_vga_en` alone.
- R10: While `cfg_live_en` and `live_pin` are both high, no request is claimed on either side. If either is low, decisions follow the enables as configured.
- R11: A request of the reserved kind (`req_kind`=11) is never claimed.
- R12: With `cfg_io_en` clear, no primary I/O request is claimed. With `cfg_mem_en` clear, no primary memory request is claimed. This holds for the window ranges and for the display ranges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Address phase present this cycle |
| req_side | input | 1 | Originating side: 0 primary, 1 secondary |
| req_kind | input | 2 | 00 I/O read, 01 I/O write, 10 memory, 11 reserved |
| req_addr | input | 32 | Transaction address |
| cfg_io_base | input | 4 | I/O window base, 4 KB page number |
| cfg_io_limit | input | 4 | I/O window limit, 4 KB page number |
| cfg_mem_base | input | 12 | Memory window base, 1 MB page number |
| cfg_mem_limit | input | 12 | Memory window limit, 1 MB page number |
| cfg_io_en | input | 1 | Enables downstream I/O claims |
| cfg_mem_en | input | 1 | Enables downstream memory claims |
| cfg_master_en | input | 1 | Enables upstream claims |
| cfg_isa_en | input | 1 | ISA alias filtering of the I/O window |
| cfg_vga_en | input | 1 | Legacy display range forwarding |
| cfg_snoop_en | input | 1 | Palette write forwarding |
| cfg_live_en | input | 1 | Arms the live-insertion mask |
| live_pin | input | 1 | Live-insertion hardware pin |
| claim_dn | output | 1 | Claim for downstream forwarding (registered) |
| claim_up | output | 1 | Claim for upstream forwarding (registered) |

## Verification
The bench builds the decoder with its default parameters: a 32-bit address, a 64 KB I/O space, 4 KB and 1 MB window granularity, 1 KB ISA blocks with a 256-byte forwarded quarter, and a 10-bit display decode. With these values every edge can be reached with short literal addresses. Vectors sit on both ends of each window and just beyond them, on the 64 KB I/O ceiling, and on alias copies of the display ports above 400h. They also cover the palette ports next to their unlisted neighbours, the quarter split inside a 1 KB block, and swapped base/limit pairs.

// File: rtl/fwd_dec_pkg.sv
`timescale 1ns/1ps
package fwd_dec_pkg;

    typedef enum logic [1:0] {
        KIND_IO_RD = 2'b00,
        KIND_IO_WR = 2'b01,
        KIND_MEM   = 2'b10,
        KIND_RSV   = 2'b11
    } fwd_kind_e;

    typedef enum logic {
        SIDE_PRI = 1'b0,
        SIDE_SEC = 1'b1
    } fwd_side_e;

    typedef struct packed {
        logic dn;
        logic up;
    } fwd_claim_t;

    // legacy display memory aperture
    localparam logic [31:0] VGA_MEM_LO = 32'h000A_0000;
    localparam logic [31:0] VGA_MEM_HI = 32'h000B_FFFF;

endpackage

// File: rtl/fwd_io_window.sv
`timescale 1ns/1ps
// I/O window compare with ISA alias filtering (R2, R4, R6)
module fwd_io_window #(
    parameter  int SEL_W = 2,
    parameter  int FLD_W = 4
) (
    input  logic             in_space,
    input  logic [FLD_W-1:0] page,
    input  logic [SEL_W-1:0] isa_sel,
    input  logic [FLD_W-1:0] base,
    input  logic [FLD_W-1:0] limit,
    input  logic             isa_en,
    output logic             fwd_dn,
    output logic             fwd_up
);
    logic in_win;
    logic isa_hold;

    always_comb begin
        in_win   = in_space && (page >= base) && (page <= limit);
        isa_hold = isa_en && in_space && (isa_sel != '0);
        fwd_dn   = in_win && !isa_hold;
        fwd_up   = !in_win || isa_hold;
    end
endmodule

// File: rtl/fwd_mem_window.sv
`timescale 1ns/1ps
// Memory window compare on 1 MB pages (R3, R4)
module fwd_mem_window #(
    parameter int FLD_W = 12
) (
    input  logic [FLD_W-1:0] page,
    input  logic [FLD_W-1:0] base,
    input  logic [FLD_W-1:0] limit,
    output logic             hit
);
    always_comb hit = (page >= base) && (page <= limit);
endmodule

// File: rtl/fwd_vga_match.sv
`timescale 1ns/1ps
// Legacy display range and palette port detection (R7, R8)
module fwd_vga_match
    import fwd_dec_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int VGA_DEC_W = 10
) (
    input  logic                 in_space,
    input  logic [ADDR_W-1:0]    addr,
    output logic                 io_hit,
    output logic                 pal_hit,
    output logic                 mem_hit
);
    localparam int NRNG = 2;
    localparam int NPAL = 3;
    localparam logic [VGA_DEC_W-1:0] RNG_LO [NRNG] = '{VGA_DEC_W'(10'h3B0), VGA_DEC_W'(10'h3C0)};
    localparam logic [VGA_DEC_W-1:0] RNG_HI [NRNG] = '{VGA_DEC_W'(10'h3BB), VGA_DEC_W'(10'h3DF)};
    localparam logic [VGA_DEC_W-1:0] PAL_AT [NPAL] =
        '{VGA_DEC_W'(10'h3C6), VGA_DEC_W'(10'h3C8), VGA_DEC_W'(10'h3C9)};

    logic [VGA_DEC_W-1:0] low;
    logic [NRNG-1:0]      rng_hit;
    logic [NPAL-1:0]      pal_at_hit;

    assign low = addr[VGA_DEC_W-1:0];

    for (genvar g = 0; g < NRNG; g++) begin : g_rng
        assign rng_hit[g] = (low >= RNG_LO[g]) && (low <= RNG_HI[g]);
    end

    for (genvar p = 0; p < NPAL; p++) begin : g_pal
        assign pal_at_hit[p] = (low == PAL_AT[p]);
    end

    always_comb begin
        io_hit  = in_space && (|rng_hit);
        pal_hit = in_space && (|pal_at_hit);
        mem_hit = (addr >= ADDR_W'(VGA_MEM_LO)) && (addr <= ADDR_W'(VGA_MEM_HI));
    end
endmodule

// File: rtl/fwd_addr_decoder.sv
`timescale 1ns/1ps
// Top: combines the range checks, enables and masks; registers the claims.
module fwd_addr_decoder
    import fwd_dec_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int IO_SPACE_W = 16,
    parameter  int IO_GRAN_W  = 12,
    parameter  int MEM_GRAN_W = 20,
    parameter  int ISA_BLK_W  = 10,
    parameter  int ISA_FWD_W  = 8,
    parameter  int VGA_DEC_W  = 10,
    localparam int IO_FLD_W   = IO_SPACE_W - IO_GRAN_W,
    localparam int MEM_FLD_W  = ADDR_W - MEM_GRAN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_vld,
    input  logic                 req_side,
    input  logic [1:0]           req_kind,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [IO_FLD_W-1:0]  cfg_io_base,
    input  logic [IO_FLD_W-1:0]  cfg_io_limit,
    input  logic [MEM_FLD_W-1:0] cfg_mem_base,
    input  logic [MEM_FLD_W-1:0] cfg_mem_limit,
    input  logic                 cfg_io_en,
    input  logic                 cfg_mem_en,
    input  logic                 cfg_master_en,
    input  logic                 cfg_isa_en,
    input  logic                 cfg_vga_en,
    input  logic                 cfg_snoop_en,
    input  logic                 cfg_live_en,
    input  logic                 live_pin,
    output logic                 claim_dn,
    output logic                 claim_up
);
    localparam int ISA_SEL_W = ISA_BLK_W - ISA_FWD_W;

    fwd_kind_e  kind;
    fwd_side_e  side;
    logic       in_space;
    logic       io_fwd_dn, io_fwd_up;
    logic       mem_in;
    logic       vga_io, vga_pal, vga_mem;
    fwd_claim_t claim_d, claim_q;

    assign kind     = fwd_kind_e'(req_kind);
    assign side     = fwd_side_e'(req_side);
    assign in_space = (req_addr[ADDR_W-1:IO_SPACE_W] == '0);

    fwd_io_window #(
        .SEL_W (ISA_SEL_W),
        .FLD_W (IO_FLD_W)
    ) io_win_i (
        .in_space (in_space),
        .page     (req_addr[IO_SPACE_W-1:IO_GRAN_W]),
        .isa_sel  (req_addr[ISA_BLK_W-1:ISA_FWD_W]),
        .base     (cfg_io_base),
        .limit    (cfg_io_limit),
        .isa_en   (cfg_isa_en),
        .fwd_dn   (io_fwd_dn),
        .fwd_up   (io_fwd_up)
    );

    fwd_mem_window #(
        .FLD_W (MEM_FLD_W)
    ) mem_win_i (
        .page  (req_addr[ADDR_W-1:MEM_GRAN_W]),
        .base  (cfg_mem_base),
        .limit (cfg_mem_limit),
        .hit   (mem_in)
    );

    fwd_vga_match #(
        .ADDR_W    (ADDR_W),
        .VGA_DEC_W (VGA_DEC_W)
    ) vga_i (
        .in_space (in_space),
        .addr     (req_addr),
        .io_hit   (vga_io),
        .pal_hit  (vga_pal),
        .mem_hit  (vga_mem)
    );

    always_comb begin
        logic mask, io_on, mem_on, mst_on, is_io, is_mem;
        logic dn_io, dn_mem, up_io, up_mem;

        // R10: hardware mask overrides the enables, not their stored values
        mask   = cfg_live_en && live_pin;
        io_on  = cfg_io_en && !mask;
        mem_on = cfg_mem_en && !mask;
        mst_on = cfg_master_en && !mask;

        // R11: reserved kind is neither I/O nor memory
        is_io  = (kind == KIND_IO_RD) || (kind == KIND_IO_WR);
        is_mem = (kind == KIND_MEM);

        // R2, R6, R7, R8, R9: mode covers the palette ports, so mode+snoop == mode
        dn_io  = io_on && (io_fwd_dn
                           || (cfg_vga_en && vga_io)
                           || (cfg_snoop_en && (kind == KIND_IO_WR) && vga_pal));
        dn_mem = mem_on && (mem_in || (cfg_vga_en && vga_mem));
        // R5, R7: upstream is the negative decode
        up_io  = io_fwd_up && !(cfg_vga_en && vga_io);
        up_mem = !mem_in && !(cfg_vga_en && vga_mem);

        claim_d = '0;
        if (req_vld) begin
            if (side == SIDE_PRI) begin
                claim_d.dn = (is_io && dn_io) || (is_mem && dn_mem);
            end else begin
                claim_d.up = mst_on && ((is_io && up_io) || (is_mem && up_mem));
            end
        end
    end

    // R1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) claim_q <= '0;
        else        claim_q <= claim_d;
    end

    assign claim_dn = claim_q.dn;
    assign claim_up = claim_q.up;
endmodule

// File: rtl/fwd_addr_decoder_chk.sv
`timescale 1ns/1ps
module fwd_addr_decoder_chk #(
    parameter int MEM_FLD_W = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_vld,
    input logic                 req_side,
    input logic [1:0]           req_kind,
    input logic [MEM_FLD_W-1:0] mem_page,
    input logic [MEM_FLD_W-1:0] cfg_mem_base,
    input logic [MEM_FLD_W-1:0] cfg_mem_limit,
    input logic                 cfg_io_en,
    input logic                 cfg_mem_en,
    input logic                 cfg_master_en,
    input logic                 cfg_live_en,
    input logic                 live_pin,
    input logic                 claim_dn,
    input logic                 claim_up
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!claim_dn && !claim_up));

    // R5
    pri_no_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_side) |=> !claim_up);

    // R5
    sec_no_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_side) |=> !claim_dn);

    // R5
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !cfg_master_en) |=> !claim_up);

    // R10
    live_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && cfg_live_en && live_pin) |=> (!claim_dn && !claim_up));

    // R11
    rsv_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && (req_kind == 2'b11)) |=> (!claim_dn && !claim_up));

    // R12
    io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_side && !req_kind[1] && !cfg_io_en) |=> !claim_dn);

    // R12
    mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_side && (req_kind == 2'b10) && !cfg_mem_en) |=> !claim_dn);

    // R3
    mem_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_side && (req_kind == 2'b10) && cfg_mem_en
         && !(cfg_live_en && live_pin)
         && (mem_page >= cfg_mem_base) && (mem_page <= cfg_mem_limit)) |=> claim_dn);
endmodule

bind fwd_addr_decoder fwd_addr_decoder_chk #(
    .MEM_FLD_W (MEM_FLD_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_vld       (req_vld),
    .req_side      (req_side),
    .req_kind      (req_kind),
    .mem_page      (req_addr[ADDR_W-1:MEM_GRAN_W]),
    .cfg_mem_base  (cfg_mem_base),
    .cfg_mem_limit (cfg_mem_limit),
    .cfg_io_en     (cfg_io_en),
    .cfg_mem_en    (cfg_mem_en),
    .cfg_master_en (cfg_master_en),
    .cfg_live_en   (cfg_live_en),
    .live_pin      (live_pin),
    .claim_dn      (claim_dn),
    .claim_up      (claim_up)
);

// File: tb/fwd_addr_decoder_tb_top.sv
`timescale 1ns/1ps
module fwd_addr_decoder_tb_top;

    localparam logic       P = 1'b0, S = 1'b1;
    localparam logic [1:0] IOR = 2'b00, IOW = 2'b01, MEM = 2'b10, RSV = 2'b11;
    // flag byte: {io_en, mem_en, master_en, isa_en, vga_en, snoop_en, live_en, live_pin}
    localparam logic [7:0] A3 = 8'hE0, F_IO = 8'h80, F_MEM = 8'h40, F_MST = 8'h20;
    localparam logic [7:0] F_ISA = 8'h10, F_VGA = 8'h08, F_SNP = 8'h04, F_LIE = 8'h02, F_PIN = 8'h01;

    typedef struct packed {
        logic [3:0]  req;
        logic        side;
        logic [1:0]  kind;
        logic [31:0] addr;
        logic [7:0]  fl;
        logic        dn;
        logic        up;
    } vec_t;

    localparam int NV = 49;
    localparam vec_t VEC [NV] = '{
        // R2: I/O window 4000h..5FFFh
        '{4'd2, P, IOR, 32'h0000_4000, A3, 1'b1, 1'b0},
        '{4'd2, P, IOW, 32'h0000_5FFF, A3, 1'b1, 1'b0},
        '{4'd2, P, IOR, 32'h0000_3FFF, A3, 1'b0, 1'b0},
        '{4'd2, P, IOR, 32'h0000_6000, A3, 1'b0, 1'b0},
        '{4'd2, P, IOR, 32'h0001_4000, A3, 1'b0, 1'b0},
        // R3: memory window 10000000h..1FFFFFFFh
        '{4'd3, P, MEM, 32'h1000_0000, A3, 1'b1, 1'b0},
        '{4'd3, P, MEM, 32'h1FFF_FFFF, A3, 1'b1, 1'b0},
        '{4'd3, P, MEM, 32'h0FFF_FFFF, A3, 1'b0, 1'b0},
        '{4'd3, P, MEM, 32'h2000_0000, A3, 1'b0, 1'b0},
        // R5: upstream negative decode
        '{4'd5, S, MEM, 32'h2000_0000, A3, 1'b0, 1'b1},
        '{4'd5, S, MEM, 32'h1000_0004, A3, 1'b0, 1'b0},
        '{4'd5, S, IOR, 32'h0000_3000, A3, 1'b0, 1'b1},
        '{4'd5, S, IOW, 32'h0000_4100, A3, 1'b0, 1'b0},
        '{4'd5, S, MEM, 32'h2000_0000, F_IO | F_MEM, 1'b0, 1'b0},
        // R6: ISA quarter split
        '{4'd6, P, IOR, 32'h0000_4100, A3 | F_ISA, 1'b0, 1'b0},
        '{4'd6, P, IOR, 32'h0000_4400, A3 | F_ISA, 1'b1, 1'b0},
        '{4'd6, P, IOR, 32'h0000_40FF, A3 | F_ISA, 1'b1, 1'b0},
        '{4'd6, S, IOW, 32'h0000_4300, A3 | F_ISA, 1'b0, 1'b1},
        '{4'd6, S, IOW, 32'h0000_4000, A3 | F_ISA, 1'b0, 1'b0},
        '{4'd6, P, IOR, 32'h0000_4100, A3, 1'b1, 1'b0},
        // R7: display ranges
        '{4'd7, P, MEM, 32'h000A_0000, A3 | F_VGA, 1'b1, 1'b0},
        '{4'd7, P, MEM, 32'h000B_FFFF, A3 | F_VGA, 1'b1, 1'b0},
        '{4'd7, P, MEM, 32'h000C_0000, A3 | F_VGA, 1'b0, 1'b0},
        '{4'd7, P, IOR, 32'h0000_03B0, A3 | F_VGA, 1'b1, 1'b0},
        '{4'd7, P, IOR, 32'h0000_03BC, A3 | F_VGA, 1'b0, 1'b0},
        '{4'd7, P, IOW, 32'h0000_07DF, A3 | F_VGA, 1'b1, 1'b0},
        '{4'd7, S, MEM, 32'h000A_8000, A3 | F_VGA, 1'b0, 1'b0},
        '{4'd7, S, MEM, 32'h000A_8000, A3, 1'b0, 1'b1},
        '{4'd7, S, IOR, 32'h0000_03C4, A3 | F_VGA, 1'b0, 1'b0},
        '{4'd7, P, MEM, 32'h000A_0000, A3, 1'b0, 1'b0},
        // R8: palette snoop
        '{4'd8, P, IOW, 32'h0000_03C6, A3 | F_SNP, 1'b1, 1'b0},
        '{4'd8, P, IOW, 32'h0000_0BC9, A3 | F_SNP, 1'b1, 1'b0},
        '{4'd8, P, IOR, 32'h0000_03C8, A3 | F_SNP, 1'b0, 1'b0},
        '{4'd8, P, IOW, 32'h0000_03C7, A3 | F_SNP, 1'b0, 1'b0},
        '{4'd8, S, IOW, 32'h0000_03C8, A3 | F_SNP, 1'b0, 1'b1},
        // R9: mode and snoop together
        '{4'd9, P, IOR, 32'h0000_03C8, A3 | F_VGA | F_SNP, 1'b1, 1'b0},
        '{4'd9, P, IOW, 32'h0000_03D0, A3 | F_VGA | F_SNP, 1'b1, 1'b0},
        '{4'd9, S, IOW, 32'h0000_03C6, A3 | F_VGA | F_SNP, 1'b0, 1'b0},
        // R10: live-insertion mask
        '{4'd10, P, MEM, 32'h1000_0000, A3 | F_LIE | F_PIN, 1'b0, 1'b0},
        '{4'd10, S, MEM, 32'h2000_0000, A3 | F_LIE | F_PIN, 1'b0, 1'b0},
        '{4'd10, P, MEM, 32'h1000_0000, A3 | F_LIE, 1'b1, 1'b0},
        '{4'd10, P, MEM, 32'h1000_0000, A3 | F_PIN, 1'b1, 1'b0},
        '{4'd10, S, IOR, 32'h0000_3000, A3 | F_LIE, 1'b0, 1'b1},
        // R11: reserved kind
        '{4'd11, P, RSV, 32'h0000_4000, A3, 1'b0, 1'b0},
        '{4'd11, S, RSV, 32'h2000_0000, A3, 1'b0, 1'b0},
        // R12: per-kind enables
        '{4'd12, P, IOR, 32'h0000_4000, F_MEM | F_MST, 1'b0, 1'b0},
        '{4'd12, P, MEM, 32'h1000_0000, F_IO | F_MST, 1'b0, 1'b0},
        '{4'd12, P, IOW, 32'h0000_03C6, F_MEM | F_MST | F_SNP | F_VGA, 1'b0, 1'b0},
        '{4'd12, P, MEM, 32'h000A_0000, F_IO | F_MST | F_VGA, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic        req_side = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [31:0] req_addr = '0;
    logic [3:0]  cfg_io_base = 4'h4, cfg_io_limit = 4'h5;
    logic [11:0] cfg_mem_base = 12'h100, cfg_mem_limit = 12'h1FF;
    logic cfg_io_en = 1'b0, cfg_mem_en = 1'b0, cfg_master_en = 1'b0, cfg_isa_en = 1'b0;
    logic cfg_vga_en = 1'b0, cfg_snoop_en = 1'b0, cfg_live_en = 1'b0, live_pin = 1'b0;
    logic claim_dn, claim_up;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fwd_addr_decoder dut_i (
        .clk (clk), .rst_n (rst_n), .req_vld (req_vld), .req_side (req_side),
        .req_kind (req_kind), .req_addr (req_addr),
        .cfg_io_base (cfg_io_base), .cfg_io_limit (cfg_io_limit),
        .cfg_mem_base (cfg_mem_base), .cfg_mem_limit (cfg_mem_limit),
        .cfg_io_en (cfg_io_en), .cfg_mem_en (cfg_mem_en), .cfg_master_en (cfg_master_en),
        .cfg_isa_en (cfg_isa_en), .cfg_vga_en (cfg_vga_en), .cfg_snoop_en (cfg_snoop_en),
        .cfg_live_en (cfg_live_en), .live_pin (live_pin),
        .claim_dn (claim_dn), .claim_up (claim_up)
    );

    task automatic check(input int req, input string what, input logic e_dn, input logic e_up);
        n_chk++;
        if (claim_dn !== e_dn || claim_up !== e_up) begin
            n_bad++;
            $display("FAIL R%0d %s: dn,up=%b%b expected %b%b", req, what, claim_dn, claim_up, e_dn, e_up);
        end
    endtask

    // drive at a falling edge; the result is visible at the next falling edge
    task automatic drive(input logic vld, input logic sd, input logic [1:0] kd,
                         input logic [31:0] ad, input logic [7:0] fl);
        @(negedge clk);
        req_vld  = vld;
        req_side = sd;
        req_kind = kd;
        req_addr = ad;
        {cfg_io_en, cfg_mem_en, cfg_master_en, cfg_isa_en,
         cfg_vga_en, cfg_snoop_en, cfg_live_en, live_pin} = fl;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state with an active request held on the inputs
        drive(1'b1, P, MEM, 32'h1000_0000, A3);
        repeat (3) @(negedge clk);
        check(1, "claims held low in reset", 1'b0, 1'b0);
        drive(1'b0, P, MEM, 32'h1000_0000, A3);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "no claim without a request after reset", 1'b0, 1'b0);

        // table walk covering R2..R12
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VEC[i].side, VEC[i].kind, VEC[i].addr, VEC[i].fl);
            @(negedge clk);
            check(int'(VEC[i].req), $sformatf("vector %0d addr %h", i, VEC[i].addr), VEC[i].dn, VEC[i].up);
        end

        // R1: one-cycle latency and drop when req_vld falls
        drive(1'b0, P, MEM, 32'h1000_0000, A3);
        @(negedge clk);
        check(1, "idle before latency probe", 1'b0, 1'b0);
        drive(1'b1, P, MEM, 32'h1000_0000, A3);
        check(1, "claim not yet visible in the request cycle", 1'b0, 1'b0);
        drive(1'b0, P, MEM, 32'h1000_0000, A3);
        check(1, "claim visible one cycle later", 1'b1, 1'b0);
        @(negedge clk);
        check(1, "claim drops after req_vld low", 1'b0, 1'b0);

        // R4: swapped base and limit
        cfg_io_base  = 4'h6;
        cfg_io_limit = 4'h5;
        drive(1'b1, P, IOR, 32'h0000_5800, A3);
        @(negedge clk);
        check(4, "inverted I/O window primary", 1'b0, 1'b0);
        drive(1'b1, S, IOR, 32'h0000_5800, A3);
        @(negedge clk);
        check(4, "inverted I/O window secondary", 1'b0, 1'b1);
        cfg_mem_base  = 12'h200;
        cfg_mem_limit = 12'h100;
        drive(1'b1, P, MEM, 32'h1800_0000, A3);
        @(negedge clk);
        check(4, "inverted memory window primary", 1'b0, 1'b0);
        drive(1'b1, S, MEM, 32'h1800_0000, A3);
        @(negedge clk);
        check(4, "inverted memory window secondary", 1'b0, 1'b1);

        // R2: single-page window, base equal to limit
        cfg_io_base  = 4'h7;
        cfg_io_limit = 4'h7;
        drive(1'b1, P, IOW, 32'h0000_7ABC, A3);
        @(negedge clk);
        check(2, "single-page I/O window", 1'b1, 1'b0);

        drive(1'b0, P, IOR, '0, 8'h00);
        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule